// File: doc/BRIEF.md
# Single-Cycle Load/Store Integer Core

This block is a small integer processor core that completes one 32-bit instruction on every rising clock edge. It holds a program counter, a file of 32 general registers of 32 bits, a decoder and an arithmetic unit, and it chooses the next instruction address in the same cycle. It drives an instruction address and receives the instruction word, and it reaches data through a second port with an address, write data, a write strobe and read data.

The instruction subset covers:
- register arithmetic: add, sub, slt, sll
- word load and store
- two-register compare branches (equal, not equal)
- the zero-compare forms (signed less-or-equal to zero, non-zero)
- an absolute jump and a jump through a register

Both memories are external. Reads are combinational. Writes to registers and to data memory take effect on the rising clock edge. Any word outside the subset passes through as a no-op.

Top module: `core_top`

## Requirements
- R1: With opcode 0, funct 0x20 writes rs+rt into rd and funct 0x22 writes rs-rt into rd. Instruction fields are op[31:26], rs[25:21], rt[20:16], rd[15:11], sa[10:6], funct[5:0], imm[15:0] and target[25:0].
- R2: With opcode 0 and funct 0x2A, rd receives 1 when rs is less than rt as signed numbers, and 0 otherwise.
- R3: With opcode 0 and funct 0x00, rd receives rt shifted left by sa.
- R4: Opcode 0x23 loads the data word at rs + sign-extended imm (a byte address) into rt.
- R5: Opcode 0x2B drives rs + sign-extended imm on the data address and rt on the write data. It asserts the write strobe for that cycle only.
- R6: Opcode 0x04 branches when rs equals rt, and opcode 0x05 branches when they differ. A taken branch goes to PC+4 + (sign-extended imm << 2). An untaken branch goes to PC+4.
- R7: Opcode 0x06 branches when rs is less than or equal to zero as a signed number. The non-zero test is opcode 0x05 with rt = 0.
- R8: Opcode 0x02 jumps to {PC+4[31:28], target, 2'b00}. Opcode 0 with funct 0x08 jumps to the address held in rs.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: An unknown opcode, or an unknown funct under opcode 0, writes no register and no memory, and advances the PC by 4.
- R11: While reset is high the instruction address is 0. Each non-control instruction advances it by 4.
- R12: The data write strobe is high only during a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| imemAddr | output | 32 | Byte address of the current instruction |
| imemData | input | 32 | Instruction word at imemAddr |
| dmemAddr | output | 32 | Data byte address (ALU result) |
| dmemWdata | output | 32 | Store data |
| dmemWe | output | 1 | Store strobe, written at the next rising edge |
| dmemRdata | input | 32 | Data word at dmemAddr |

## Verification
A register holding a wrong value shows up at the ports only when a later store writes it out, or when a branch or register jump consumes it and bends the instruction address. The test programs therefore store every computed result to its own memory word. A wrong next-PC decision appears on imemAddr one clock later: a skipped marker store is missing, or an extra marker store appears, and the final self-loop address comes out different. Writes to register 0 and to unknown encodings are caught by storing the possibly clobbered register right afterwards.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RIDX = $clog2(NREG);
  localparam int SHW  = $clog2(XLEN);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JUMP  = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_BNE   = 6'h05;
  localparam logic [5:0] OP_BLEZ  = 6'h06;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;

  localparam logic [5:0] FN_SLL = 6'h00;
  localparam logic [5:0] FN_JR  = 6'h08;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_SLT, ALU_SLL} aluOp_e;
  typedef enum logic [1:0] {BR_NONE, BR_EQ, BR_NE, BR_LEZ} brKind_e;

  typedef struct packed {
    logic    regWrite;
    logic    memWrite;
    logic    memToReg;
    logic    aluSrcImm;
    logic    dstIsRd;
    aluOp_e  aluOp;
    brKind_e brKind;
    logic    jump;
    logic    jumpReg;
  } ctrlStrb_t;
endpackage

// File: rtl/core_regfile.sv
module core_regfile
  import core_pkg::*;
#(
  parameter int W = XLEN,
  parameter int N = NREG
) (
  input  logic                 clk,
  input  logic [$clog2(N)-1:0] rAddrA,
  input  logic [$clog2(N)-1:0] rAddrB,
  output logic [W-1:0]         rDataA,
  output logic [W-1:0]         rDataB,
  input  logic                 wEn,
  input  logic [$clog2(N)-1:0] wAddr,
  input  logic [W-1:0]         wData
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (wEn && (wAddr != '0)) regs[wAddr] <= wData;
  end

  assign rDataA = (rAddrA == '0) ? '0 : regs[rAddrA];
  assign rDataB = (rAddrB == '0) ? '0 : regs[rAddrB];
endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int W = XLEN
) (
  input  aluOp_e               op,
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  input  logic [$clog2(W)-1:0] shamt,
  output logic [W-1:0]         y
);
  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = ($signed(a) < $signed(b)) ? W'(1) : '0;
      ALU_SLL: y = b << shamt;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/core_ctrl.sv
module core_ctrl
  import core_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrlStrb_t strb
);
  logic legal;

  always_comb begin
    strb  = '0;
    legal = 1'b1;
    unique case (opcode)
      OP_RTYPE: begin
        strb.dstIsRd = 1'b1;
        unique case (funct)
          FN_ADD: begin strb.regWrite = 1'b1; strb.aluOp = ALU_ADD; end
          FN_SUB: begin strb.regWrite = 1'b1; strb.aluOp = ALU_SUB; end
          FN_SLT: begin strb.regWrite = 1'b1; strb.aluOp = ALU_SLT; end
          FN_SLL: begin strb.regWrite = 1'b1; strb.aluOp = ALU_SLL; end
          FN_JR:  strb.jumpReg = 1'b1;
          default: legal = 1'b0;
        endcase
      end
      OP_LOAD: begin
        strb.regWrite  = 1'b1;
        strb.memToReg  = 1'b1;
        strb.aluSrcImm = 1'b1;
      end
      OP_STORE: begin
        strb.memWrite  = 1'b1;
        strb.aluSrcImm = 1'b1;
      end
      OP_BEQ:  strb.brKind = BR_EQ;
      OP_BNE:  strb.brKind = BR_NE;
      OP_BLEZ: strb.brKind = BR_LEZ;
      OP_JUMP: strb.jump = 1'b1;
      default: legal = 1'b0;
    endcase
  end

  // R10: unrecognised encodings leave every strobe idle
  assert_unknown_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !legal |-> (!strb.regWrite && !strb.memWrite && strb.brKind == BR_NONE
                && !strb.jump && !strb.jumpReg));

  // R12: store strobe only under the store opcode
  assert_store_only_R12: assert property (@(posedge clk) disable iff (rst)
    strb.memWrite |-> (opcode == OP_STORE));

  // R8: at most one control-transfer kind per word
  assert_one_transfer_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.jump, strb.jumpReg, strb.brKind != BR_NONE}));
endmodule

// File: rtl/core_dpath.sv
module core_dpath
  import core_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  ctrlStrb_t       strb,
  input  logic [25:0]     instrLo,
  output logic [XLEN-1:0] pcOut,
  output logic [XLEN-1:0] dmemAddr,
  output logic [XLEN-1:0] dmemWdata,
  input  logic [XLEN-1:0] dmemRdata
);
  logic [XLEN-1:0] pcQ, pcNext, pcPlus4, brTarget, jTarget;
  logic [XLEN-1:0] rdA, rdB, immExt, aluB, aluY, wbData;
  logic [RIDX-1:0] rsIdx, rtIdx, rdIdx, wIdx;
  logic [SHW-1:0]  saAmt;
  logic            brTaken, seqStep;

  assign rsIdx  = instrLo[25:21];
  assign rtIdx  = instrLo[20:16];
  assign rdIdx  = instrLo[15:11];
  assign saAmt  = instrLo[10:6];
  assign immExt = {{(XLEN-16){instrLo[15]}}, instrLo[15:0]};

  core_regfile #(.W(XLEN), .N(NREG)) rf_i (
    .clk(clk), .rAddrA(rsIdx), .rAddrB(rtIdx), .rDataA(rdA), .rDataB(rdB),
    .wEn(strb.regWrite), .wAddr(wIdx), .wData(wbData));

  assign aluB = strb.aluSrcImm ? immExt : rdB;

  core_alu #(.W(XLEN)) alu_i (
    .op(strb.aluOp), .a(rdA), .b(aluB), .shamt(saAmt), .y(aluY));

  assign wIdx      = strb.dstIsRd ? rdIdx : rtIdx;
  assign wbData    = strb.memToReg ? dmemRdata : aluY;
  assign dmemAddr  = aluY;
  assign dmemWdata = rdB;

  always_comb begin
    unique case (strb.brKind)
      BR_EQ:   brTaken = (rdA == rdB);
      BR_NE:   brTaken = (rdA != rdB);
      BR_LEZ:  brTaken = ($signed(rdA) <= 0);
      default: brTaken = 1'b0;
    endcase
  end

  assign pcPlus4  = pcQ + XLEN'(4);
  assign brTarget = pcPlus4 + (immExt << 2);
  assign jTarget  = {pcPlus4[XLEN-1:XLEN-4], instrLo, 2'b00};
  assign seqStep  = (strb.brKind == BR_NONE) && !strb.jump && !strb.jumpReg;

  always_comb begin
    if (strb.jumpReg)   pcNext = rdA;
    else if (strb.jump) pcNext = jTarget;
    else if (brTaken)   pcNext = brTarget;
    else                pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pcQ <= RESET_PC;
    else     pcQ <= pcNext;
  end

  assign pcOut = pcQ;

  // R11: the cycle after reset the PC sits at its reset value
  assert_reset_pc_R11: assert property (@(posedge clk)
    $past(rst) |-> (pcQ == RESET_PC));

  // R11: plain instructions step by one word
  assert_seq_step_R11: assert property (@(posedge clk) disable iff (rst)
    seqStep |=> (pcQ == $past(pcQ) + XLEN'(4)));

  // R6: a taken branch lands on its computed target
  assert_branch_land_R6: assert property (@(posedge clk) disable iff (rst)
    brTaken |=> (pcQ == $past(brTarget)));

  // R8: a register jump lands on the register value
  assert_jr_land_R8: assert property (@(posedge clk) disable iff (rst)
    strb.jumpReg |=> (pcQ == $past(rdA)));
endmodule

// File: rtl/core_top.sv
module core_top
  import core_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imemAddr,
  input  logic [31:0] imemData,
  output logic [31:0] dmemAddr,
  output logic [31:0] dmemWdata,
  output logic        dmemWe,
  input  logic [31:0] dmemRdata
);
  ctrlStrb_t strb;

  core_ctrl ctrl_i (
    .clk(clk), .rst(rst), .opcode(imemData[31:26]), .funct(imemData[5:0]),
    .strb(strb));

  core_dpath #(.RESET_PC(RESET_PC)) dpath_i (
    .clk(clk), .rst(rst), .strb(strb), .instrLo(imemData[25:0]),
    .pcOut(imemAddr), .dmemAddr(dmemAddr), .dmemWdata(dmemWdata),
    .dmemRdata(dmemRdata));

  assign dmemWe = strb.memWrite;
endmodule

// File: tb/core_top_tb_top.sv
module core_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] imemAddr, imemData, dmemAddr, dmemWdata, dmemRdata;
  logic dmemWe;
  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  core_top dut_i (
    .clk(clk), .rst(rst), .imemAddr(imemAddr), .imemData(imemData),
    .dmemAddr(dmemAddr), .dmemWdata(dmemWdata), .dmemWe(dmemWe),
    .dmemRdata(dmemRdata));

  assign imemData  = imem[imemAddr[7:2]];
  assign dmemRdata = dmem[dmemAddr[7:2]];
  always @(posedge clk) if (dmemWe) dmem[dmemAddr[7:2]] <= dmemWdata;

  function automatic logic [31:0] encR(int rs, int rt, int rd, int sa, int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], sa[4:0], fn[5:0]};
  endfunction
  function automatic logic [31:0] encI(int op, int rs, int rt, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] encJ(int tgt);
    return {6'h02, tgt[25:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearMems();
    for (int i = 0; i < 64; i++) begin imem[i] = 32'h0; dmem[i] = 32'h0; end
  endtask

  task automatic runFromReset(int cycles);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic testReset();
    clearMems();
    imem[0] = encI(8'h23, 0, 1, 0);
    imem[1] = encI(8'h23, 0, 2, 4);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 reset address", imemAddr, 32'h0);
    check("R12 no strobe on load", {31'b0, dmemWe}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R11 step by four", imemAddr, 32'h4);
    @(negedge clk);
    check("R11 second step", imemAddr, 32'h8);
  endtask

  task automatic testArith();
    clearMems();
    dmem[0] = 32'd5; dmem[1] = 32'd7; dmem[2] = 32'hFFFF_FFFD;
    imem[0]  = encI(8'h23, 0, 1, 0);
    imem[1]  = encI(8'h23, 0, 2, 4);
    imem[2]  = encI(8'h23, 0, 3, 8);
    imem[3]  = encR(1, 2, 4, 0, 8'h20);
    imem[4]  = encR(1, 2, 5, 0, 8'h22);
    imem[5]  = encR(3, 1, 6, 0, 8'h2A);
    imem[6]  = encR(1, 3, 7, 0, 8'h2A);
    imem[7]  = encR(0, 1, 8, 4, 8'h00);
    imem[8]  = encI(8'h2B, 0, 4, 16);
    imem[9]  = encI(8'h2B, 0, 5, 20);
    imem[10] = encI(8'h2B, 0, 6, 24);
    imem[11] = encI(8'h2B, 0, 7, 28);
    imem[12] = encI(8'h2B, 0, 8, 32);
    imem[13] = encR(1, 2, 0, 0, 8'h20);
    imem[14] = encI(8'h2B, 0, 0, 36);
    imem[15] = encI(8'h2B, 4, 2, 32);
    imem[16] = encR(1, 0, 10, 0, 8'h20);
    imem[17] = encI(8'h3F, 1, 10, 16);
    imem[18] = encR(1, 2, 10, 0, 8'h3F);
    imem[19] = encI(8'h2B, 0, 10, 48);
    imem[20] = encI(8'h23, 4, 11, -4);
    imem[21] = encI(8'h2B, 0, 11, 52);
    imem[22] = encI(8'h04, 0, 0, -1);
    runFromReset(40);
    check("R1 add", dmem[4], 32'd12);
    check("R1 sub", dmem[5], 32'hFFFF_FFFE);
    check("R2 slt negative vs positive", dmem[6], 32'd1);
    check("R2 slt positive vs negative", dmem[7], 32'd0);
    check("R3 sll by 4", dmem[8], 32'd80);
    check("R9 r0 stays zero", dmem[9], 32'd0);
    check("R5 store with register base", dmem[11], 32'd7);
    check("R10 unknown op/funct no write", dmem[12], 32'd5);
    check("R4 load negative offset", dmem[13], 32'hFFFF_FFFD);
    check("R12 untouched word", dmem[10], 32'd0);
    check("R4 load source intact", dmem[2], 32'hFFFF_FFFD);
    check("R6 backward self loop", imemAddr, 32'd88);
  endtask

  task automatic testBranches();
    clearMems();
    dmem[0] = 32'd5; dmem[1] = 32'hFFFF_FFFD; dmem[2] = 32'h55; dmem[3] = 32'd124;
    imem[0]  = encI(8'h23, 0, 1, 0);
    imem[1]  = encI(8'h23, 0, 2, 0);
    imem[2]  = encI(8'h23, 0, 3, 4);
    imem[3]  = encI(8'h23, 0, 9, 8);
    imem[4]  = encI(8'h04, 1, 2, 1);
    imem[5]  = encI(8'h2B, 0, 9, 16);
    imem[6]  = encI(8'h04, 1, 3, 1);
    imem[7]  = encI(8'h2B, 0, 9, 20);
    imem[8]  = encI(8'h05, 1, 3, 1);
    imem[9]  = encI(8'h2B, 0, 9, 24);
    imem[10] = encI(8'h05, 1, 2, 1);
    imem[11] = encI(8'h2B, 0, 9, 28);
    imem[12] = encI(8'h06, 3, 0, 1);
    imem[13] = encI(8'h2B, 0, 9, 32);
    imem[14] = encI(8'h06, 0, 0, 1);
    imem[15] = encI(8'h2B, 0, 9, 36);
    imem[16] = encI(8'h06, 1, 0, 1);
    imem[17] = encI(8'h2B, 0, 9, 40);
    imem[18] = encI(8'h05, 1, 0, 1);
    imem[19] = encI(8'h2B, 0, 9, 44);
    imem[20] = encI(8'h05, 0, 0, 1);
    imem[21] = encI(8'h2B, 0, 9, 48);
    imem[22] = encJ(25);
    imem[23] = encI(8'h2B, 0, 9, 52);
    imem[24] = encI(8'h2B, 0, 9, 56);
    imem[25] = encI(8'h23, 0, 4, 12);
    imem[26] = encR(4, 0, 0, 0, 8'h08);
    imem[27] = encI(8'h2B, 0, 9, 60);
    imem[31] = encI(8'h2B, 0, 9, 64);
    imem[32] = encI(8'h04, 0, 0, -1);
    runFromReset(60);
    check("R6 beq taken skips", dmem[4], 32'h0);
    check("R6 beq not taken", dmem[5], 32'h55);
    check("R6 bne taken skips", dmem[6], 32'h0);
    check("R6 bne not taken", dmem[7], 32'h55);
    check("R7 blez negative taken", dmem[8], 32'h0);
    check("R7 blez zero taken", dmem[9], 32'h0);
    check("R7 blez positive not taken", dmem[10], 32'h55);
    check("R7 bnez nonzero taken", dmem[11], 32'h0);
    check("R7 bnez zero not taken", dmem[12], 32'h55);
    check("R8 j skips first", dmem[13], 32'h0);
    check("R8 j skips second", dmem[14], 32'h0);
    check("R8 jr skips", dmem[15], 32'h0);
    check("R8 jr lands", dmem[16], 32'h55);
    check("R6 final loop address", imemAddr, 32'd128);
    rst = 1'b1;
    @(negedge clk);
    check("R11 reset mid-run", imemAddr, 32'h0);
    rst = 1'b0;
  endtask

  initial begin
    testReset();
    testArith();
    testBranches();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule